// File: doc/BRIEF.md
# Ones' Complement Signed Adder/Subtractor

This block adds or subtracts two 4-bit signed operands held in ones' complement form, without any clock or state. A single operation select chooses the function: at 0 the second operand is used as it is, at 1 each of its bits is inverted, which negates it in ones' complement. The same adder datapath serves both operations.

The two effective operands are first summed with no carry in. The carry out of that first sum is then added into the least significant bit by a separate increment stage. This end-around carry therefore needs no combinational feedback path. The block produces a 4-bit ones' complement result and an overflow flag for results that leave the range -7..+7. Both 0000 and 1111 are treated as zero, and either can appear on the output.

Top module: `oc_addsub`

## Requirements
- R1: When the ideal signed result (A plus B, or A minus B) lies in -7..+7, the signed ones' complement value of `sum_o` equals it. A negative value n is encoded as the bitwise inverse of |n|.
- R2: With `sub_i` = 0 the second operand passes unchanged. For example, A plus 0000 returns A bit for bit.
- R3: With `sub_i` = 1 every bit of the second operand is inverted. For example, any A minus the same A returns 1111.
- R4: A carry out of bit 3 of the first sum is added back into bit 0. For example, 1111 plus 0001 gives 0001, and 0110 minus 0010 gives 0100.
- R5: `ovf_o` is 1 when both effective operands share a sign bit and the sign bit of `sum_o` differs from it. For example, 0011 plus 0111 gives 1010 with `ovf_o` = 1.
- R6: `ovf_o` is 0 whenever the two effective operands have different sign bits.
- R7: A zero result is encoded as 0000 only when both effective operands are 0000. Every other zero result is 1111 (for example, 0000 plus 1111 and 1111 plus 1111 both give 1111).
- R8: On overflow, `sum_o` holds the ideal result wrapped by 15. A result above +7 reads as the ideal minus 15, and a result below -7 reads as the ideal plus 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand, ones' complement |
| b_i | input | 4 | Second operand, ones' complement |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| sum_o | output | 4 | Result, ones' complement |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The bench targets the end-around carry. A design that dropped it would be off by one on every sum that crosses zero, for example 1111 plus 0001 giving 0000. It also targets which zero encoding appears, since a result of 0000 where 1111 is expected means the wrong carry handling. The overflow corners 0011 plus 0111, 0111 plus 0111 and 1000 plus 1000 expose a flag taken from the carry instead of from the signs, and they expose a wrong wrapped value. Subtraction of equal operands checks that the inversion reaches every bit of B.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int unsigned OC_W   = 4;
    localparam int unsigned OC_MSB = OC_W - 1;

    typedef logic [OC_W-1:0] oc_word_t;

    typedef enum logic {
        OC_ADD = 1'b0,
        OC_SUB = 1'b1
    } oc_op_e;

    typedef struct packed {
        logic     carry;
        oc_word_t bits;
    } oc_raw_t;

    function automatic logic oc_sign(input oc_word_t w);
        return w[OC_MSB];
    endfunction

    function automatic logic oc_is_ones(input oc_word_t w);
        return &w;
    endfunction

endpackage

// File: rtl/oc_operand_cond.sv
module oc_operand_cond
    import oc_pkg::*;
#(
    parameter int unsigned W = OC_W
) (
    input  logic [W-1:0] opnd_i,
    input  oc_op_e       op_i,
    output logic [W-1:0] opnd_eff_o
);

    logic invert;
    assign invert = (op_i == OC_SUB);

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign opnd_eff_o[gi] = opnd_i[gi] ^ invert;
    end

endmodule

// File: rtl/oc_raw_adder.sv
module oc_raw_adder
    import oc_pkg::*;
(
    input  oc_word_t x_i,
    input  oc_word_t y_i,
    output oc_raw_t  raw_o
);

    logic [OC_W:0] total;

    always_comb begin
        total = {1'b0, x_i} + {1'b0, y_i};
        raw_o = oc_raw_t'(total);
    end

endmodule

// File: rtl/oc_eac_inc.sv
module oc_eac_inc
    import oc_pkg::*;
(
    input  oc_raw_t  raw_i,
    output oc_word_t res_o
);

    assign res_o = raw_i.bits + oc_word_t'(raw_i.carry);

    // R4: a raw carry means the low bits are not all ones, so the add-back never wraps
    always_comb begin
        a_r4_no_wrap: assert (!(raw_i.carry && oc_is_ones(raw_i.bits)))
            else $error("R4 end-around increment wrapped");
    end

endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
    import oc_pkg::*;
(
    input  logic [3:0] a_i,
    input  logic [3:0] b_i,
    input  logic       sub_i,
    output logic [3:0] sum_o,
    output logic       ovf_o
);

    oc_op_e   op;
    oc_word_t b_eff;
    oc_raw_t  raw;
    oc_word_t res;

    assign op = oc_op_e'(sub_i);

    oc_operand_cond #(.W(OC_W)) u_cond (
        .opnd_i    (b_i),
        .op_i      (op),
        .opnd_eff_o(b_eff)
    );

    oc_raw_adder u_raw (
        .x_i  (a_i),
        .y_i  (b_eff),
        .raw_o(raw)
    );

    oc_eac_inc u_inc (
        .raw_i(raw),
        .res_o(res)
    );

    logic same_sign;
    assign same_sign = (oc_sign(a_i) == oc_sign(b_eff));
    assign sum_o     = res;
    assign ovf_o     = same_sign && (oc_sign(res) != oc_sign(a_i));

    always_comb begin
        // R2: adding zero leaves A untouched
        a_r2_add_zero: assert (!(!sub_i && b_i == 4'b0000) || sum_o == a_i)
            else $error("R2 A plus 0000 changed A");
        // R3: A minus A is negative zero
        a_r3_self_sub: assert (!(sub_i && a_i == b_i) || sum_o == 4'b1111)
            else $error("R3 A minus A not 1111");
        // R5: an overflow always flips the sign away from A
        a_r5_ovf_sign: assert (!ovf_o || (sum_o[3] != a_i[3]))
            else $error("R5 overflow with unchanged sign");
        // R6: mixed-sign operands never overflow
        a_r6_no_overflow: assert (!(a_i[3] != (b_i[3] ^ sub_i)) || !ovf_o)
            else $error("R6 overflow on mixed signs");
    end

endmodule

// File: tb/oc_addsub_bench.sv
module oc_addsub_bench;

    logic       clk = 1'b0;
    logic [3:0] a, b;
    logic       sub;
    logic [3:0] sum;
    logic       ovf;
    int         n_chk  = 0;
    int         n_fail = 0;
    int         cycles = 0;
    bit         done   = 0;

    always #2.5 clk = ~clk;

    oc_addsub u_oc_addsub (
        .a_i  (a),
        .b_i  (b),
        .sub_i(sub),
        .sum_o(sum),
        .ovf_o(ovf)
    );

    function automatic int val_of(input logic [3:0] x);
        logic [3:0] inv;
        inv = ~x;
        return x[3] ? -int'(inv) : int'(x);
    endfunction

    function automatic logic [3:0] enc_of(input int v);
        logic [3:0] mag;
        if (v >= 0) return 4'(v);
        mag = 4'(-v);
        return ~mag;
    endfunction

    task automatic apply(input logic [3:0] ta, input logic [3:0] tb_v, input logic ts,
                         input string tag);
        logic [3:0] beff, exp_sum;
        int         ideal, wrapped;
        logic       exp_ovf;
        a = ta; b = tb_v; sub = ts;
        #2;
        beff  = ts ? ~tb_v : tb_v;
        ideal = val_of(ta) + val_of(beff);
        exp_ovf = (ideal > 7) || (ideal < -7);
        wrapped = ideal > 7 ? ideal - 15 : (ideal < -7 ? ideal + 15 : ideal);
        if (wrapped == 0)
            exp_sum = (ta == 4'b0000 && beff == 4'b0000) ? 4'b0000 : 4'b1111;
        else
            exp_sum = enc_of(wrapped);
        n_chk++;
        if (sum !== exp_sum || ovf !== exp_ovf) begin
            n_fail++;
            $display("FAIL %s a=%b b=%b sub=%b: got sum=%b ovf=%b, expected sum=%b ovf=%b",
                     tag, ta, tb_v, ts, sum, ovf, exp_sum, exp_ovf);
        end
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        a = '0; b = '0; sub = 1'b0;
        // idle state: zero inputs give positive zero, no overflow (R7)
        apply(4'b0000, 4'b0000, 1'b0, "R7 idle zero");
        // directed corners
        apply(4'b0101, 4'b0000, 1'b0, "R2 add zero");
        apply(4'b1010, 4'b0000, 1'b0, "R2 add zero neg");
        apply(4'b0101, 4'b0101, 1'b1, "R3 self sub");
        apply(4'b0000, 4'b0000, 1'b1, "R3 zero minus zero");
        apply(4'b1111, 4'b0001, 1'b0, "R4 end-around");
        apply(4'b0110, 4'b0010, 1'b1, "R4 sub carry");
        apply(4'b0011, 4'b0111, 1'b0, "R5 overflow 3+7");
        apply(4'b0111, 4'b0111, 1'b0, "R8 overflow 7+7");
        apply(4'b1000, 4'b1000, 1'b0, "R8 overflow -7-7");
        apply(4'b0111, 4'b1000, 1'b0, "R6 mixed signs");
        apply(4'b0000, 4'b1111, 1'b0, "R7 zero plus negzero");
        apply(4'b1111, 4'b1111, 1'b0, "R7 negzero twice");
        // exhaustive sweep (R1)
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    apply(4'(i), 4'(j), 1'(s), "R1 sweep");
        // seeded random mix
        seed = 32'd2024;
        void'($urandom(seed));
        for (int k = 0; k < 200; k++)
            apply(4'($urandom), 4'($urandom), 1'($urandom), "R1 random");
        finish_run();
    end

endmodule